// File: doc/BRIEF.md
# Multi-Mode Quadrature Pulse Counter

This block counts transitions on two phase inputs, A and B, during a gating window whose length is given in system clock cycles. It offers single-phase counting on A, either always upward or with the level of B selecting the direction. It also offers quadrature counting of the A/B pair at one, two or four counts per full input cycle. In quadrature modes the direction follows whether A leads or trails B.

Software programs the block through a small register bus with a control word, a window length, a latched result, a live result, an interrupt status bit and an interrupt enable bit. In one-shot operation the counter runs for one window, then freezes, latches the count and flags an interrupt. In continuous operation it never stops. A live register can either follow the running count or take one coherent snapshot per window. Both phase inputs pass through synchronisers before edge detection. Turning frequency readings into physical units is left to software.

Register map (byte offsets): control 0x00, window 0x04, result 0x08, live 0x0C, status 0x10, interrupt enable 0x14. Reads are combinational on `addr_i`.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: A write to control (bit 0 run, bit 1 continuous, bits 5:3 mode, bit 7 snapshot) or to interrupt enable (bit 0) changes low bit i only when bit i+16 of the written word is 1. The window register takes all 32 bits as written.
- R3: Mode 0 adds one on each rising A edge. Mode 1 acts on each rising A edge: it adds one when B is high and subtracts one when B is low.
- R4: Mode 2 acts on each rising A edge with B steady: it adds one when B is low and subtracts one when B is high. Mode 3 acts on every A edge with B steady: it adds one when the new A differs from B and subtracts one otherwise. The forward sequence of (A,B) is 00,10,11,01.
- R5: Mode 4 counts every single-phase change, up for the forward sequence and down for the reverse. A step where A and B change in the same sample is ignored.
- R6: Mode codes 5, 6 and 7 leave the count at zero.
- R7: In one-shot mode with window N>0, the count stops N cycles after the run starts. The count is then copied to the result register and status bit 0 is set. The result register changes at no other time.
- R8: In one-shot mode a window of 0 never runs: nothing is counted and no status is raised.
- R9: Continuous mode never stops and never sets status. The live register changes only in continuous mode. With snapshot set it loads the count at each window end, and the count carries across windows. With snapshot clear it follows the count every cycle.
- R10: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A new latch in the same cycle wins over the clear. `irq_o` is high exactly when status bit 0 and enable bit 0 are both 1.
- R11: Clearing the run bit zeroes the running count and the window timer but keeps the result register. While running, the count moves by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| phase_a_i | input | 1 | Phase A, asynchronous |
| phase_b_i | input | 1 | Phase B, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. The count steps by at most one, a disabled counter holds zero, and the result changes only on a one-shot window end. Each window end also sets status and leaves the result equal to the frozen count, continuous mode never produces such an end, and the interrupt is never high without status. The decoding of each counting mode, the rejection of double transitions, the exact window length, the snapshot timing and the masked writes are shown only by the bench's scenarios, which compare read-back values with counts worked out by hand.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int DATA_W = 32;
  localparam int MASK_SH = 16;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_WIN  = 8'h04;
  localparam logic [7:0] OFS_RES  = 8'h08;
  localparam logic [7:0] OFS_LIVE = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;

  localparam int B_RUN  = 0;
  localparam int B_CONT = 1;
  localparam int B_MODE = 3;
  localparam int B_SNAP = 7;

  typedef enum logic [2:0] {
    M_A_UP    = 3'd0,
    M_A_DIR   = 3'd1,
    M_QUAD_X1 = 3'd2,
    M_QUAD_X2 = 3'd3,
    M_QUAD_X4 = 3'd4
  } cnt_mode_e;

  typedef struct packed {
    logic       snap;
    logic [2:0] mode;
    logic       cont;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/qpc_phase_sync.sv
module qpc_phase_sync #(
  parameter int STAGES = 2,
  parameter int NPH    = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] ph_i,
  output logic [NPH-1:0] lvl_o,
  output logic [NPH-1:0] prv_o
);
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic [STAGES-1:0] sh_q;
    logic              prv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        prv_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[STAGES-2:0], ph_i[g]};
        prv_q <= sh_q[STAGES-1];
      end
    end
    assign lvl_o[g] = sh_q[STAGES-1];
    assign prv_o[g] = prv_q;
  end
endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
  import qpc_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] lvl_i,  // [0]=A [1]=B
  input  logic [1:0] prv_i,
  output logic       up_o,
  output logic       dn_o
);
  logic a_chg, b_chg, a_rise, fwd;

  assign a_chg  = lvl_i[0] ^ prv_i[0];
  assign b_chg  = lvl_i[1] ^ prv_i[1];
  assign a_rise = a_chg & lvl_i[0];

  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    fwd  = 1'b0;
    case (cnt_mode_e'(mode_i))
      M_A_UP: up_o = a_rise;
      M_A_DIR: if (a_rise) begin
        up_o = lvl_i[1];
        dn_o = !lvl_i[1];
      end
      M_QUAD_X1: if (a_rise && !b_chg) begin
        up_o = !lvl_i[1];
        dn_o = lvl_i[1];
      end
      M_QUAD_X2: if (a_chg && !b_chg) begin
        fwd  = lvl_i[0] ^ lvl_i[1];
        up_o = fwd;
        dn_o = !fwd;
      end
      M_QUAD_X4: if (a_chg ^ b_chg) begin
        fwd  = a_chg ? (lvl_i[0] ^ lvl_i[1]) : !(lvl_i[0] ^ lvl_i[1]);
        up_o = fwd;
        dn_o = !fwd;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qpc_window_core.sv
module qpc_window_core #(
  parameter int CNT_W = 32,
  parameter int TMR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cont_i,
  input  logic             snap_i,
  input  logic [TMR_W-1:0] window_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] live_o,
  output logic             done_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, res_q, live_q;
  logic             stop_q, active, win_zero, win_end;

  assign win_zero = (window_i == '0);
  assign active   = run_i && !stop_q && (cont_i || !win_zero);
  assign win_end  = active && !win_zero && (tmr_q == window_i - TMR_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (up_i)      cnt_d = cnt_q + CNT_W'(1);
    else if (dn_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (!run_i) begin
      tmr_q  <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_d;
      tmr_q <= win_end ? '0 : tmr_q + TMR_W'(1);
      if (win_end && !cont_i) stop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      live_q <= '0;
    end else begin
      if (win_end && !cont_i) res_q <= cnt_d;
      if (active && cont_i && (!snap_i || win_end)) live_q <= cnt_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign result_o = res_q;
  assign live_o   = live_q;
  assign done_o   = win_end && !cont_i;
endmodule

// File: rtl/qpc_regs.sv
module qpc_regs
  import qpc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32,
  parameter int TMR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  result_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic [TMR_W-1:0]  window_o,
  output logic              stat_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [TMR_W-1:0] win_q;
  logic             stat_q, ien_q, wr;

  assign wr = req_i && we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ofs[ADDR_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      win_q  <= '0;
      ien_q  <= 1'b0;
    end else if (wr) begin
      if (hit(addr_i, OFS_CTRL)) begin
        if (wdata_i[MASK_SH+B_RUN])  ctrl_q.run  <= wdata_i[B_RUN];
        if (wdata_i[MASK_SH+B_CONT]) ctrl_q.cont <= wdata_i[B_CONT];
        for (int i = 0; i < 3; i++)
          if (wdata_i[MASK_SH+B_MODE+i]) ctrl_q.mode[i] <= wdata_i[B_MODE+i];
        if (wdata_i[MASK_SH+B_SNAP]) ctrl_q.snap <= wdata_i[B_SNAP];
      end
      if (hit(addr_i, OFS_WIN)) win_q <= wdata_i[TMR_W-1:0];
      if (hit(addr_i, OFS_IEN) && wdata_i[MASK_SH]) ien_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else if (done_i) stat_q <= 1'b1;
    else if (wr && hit(addr_i, OFS_STAT) && wdata_i[0]) stat_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFS_CTRL)) begin
      rdata_o[B_RUN]            = ctrl_q.run;
      rdata_o[B_CONT]           = ctrl_q.cont;
      rdata_o[B_MODE+2:B_MODE]  = ctrl_q.mode;
      rdata_o[B_SNAP]           = ctrl_q.snap;
    end
    if (hit(addr_i, OFS_WIN))  rdata_o = DATA_W'(win_q);
    if (hit(addr_i, OFS_RES))  rdata_o = DATA_W'(result_i);
    if (hit(addr_i, OFS_LIVE)) rdata_o = DATA_W'(live_i);
    if (hit(addr_i, OFS_STAT)) rdata_o[0] = stat_q;
    if (hit(addr_i, OFS_IEN))  rdata_o[0] = ien_q;
  end

  assign ctrl_o   = ctrl_q;
  assign window_o = win_q;
  assign stat_o   = stat_q;
  assign irq_o    = stat_q && ien_q;
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 32,
  parameter int TMR_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [TMR_W-1:0] window;
  logic [1:0]       ph_lvl, ph_prv;
  logic             step_up, step_dn, win_done, stat;
  logic [CNT_W-1:0] run_cnt, res_val, live_val;

  qpc_phase_sync #(.STAGES(SYNC_STAGES), .NPH(2)) u_sync (
    .clk_i, .rst_ni,
    .ph_i ({phase_b_i, phase_a_i}),
    .lvl_o(ph_lvl),
    .prv_o(ph_prv)
  );

  qpc_step_decode u_dec (
    .mode_i(ctrl.mode),
    .lvl_i (ph_lvl),
    .prv_i (ph_prv),
    .up_o  (step_up),
    .dn_o  (step_dn)
  );

  qpc_window_core #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_core (
    .clk_i, .rst_ni,
    .run_i   (ctrl.run),
    .cont_i  (ctrl.cont),
    .snap_i  (ctrl.snap),
    .window_i(window),
    .up_i    (step_up),
    .dn_i    (step_dn),
    .cnt_o   (run_cnt),
    .result_o(res_val),
    .live_o  (live_val),
    .done_o  (win_done)
  );

  qpc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .result_i(res_val),
    .live_i  (live_val),
    .done_i  (win_done),
    .ctrl_o  (ctrl),
    .window_o(window),
    .stat_o  (stat),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             cont_i,
  input logic             done_i,
  input logic             stat_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] result_i
);
  AST_DONE_SETS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_i); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(result_i)); // R7

  AST_LATCH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!en_i || result_i == cnt_i)); // R7

  AST_NO_CONT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_i |-> !done_i); // R9

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> stat_i); // R10

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0)); // R11

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1)
              || cnt_i == $past(cnt_i) - CNT_W'(1))); // R11
endmodule

bind quad_pulse_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (ctrl.run),
  .cont_i  (ctrl.cont),
  .done_i  (win_done),
  .stat_i  (stat),
  .irq_i   (irq_o),
  .cnt_i   (run_cnt),
  .result_i(res_val)
);

// File: tb/quad_pulse_counter_bench.sv
module quad_pulse_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_WIN = 5'h04, A_RES = 5'h08,
                         A_LIVE = 5'h0C, A_STAT = 5'h10, A_IEN = 5'h14;
  localparam int NVEC = 11;
  // {mode, forward steps, reverse steps, expected result}
  localparam logic [50:0] VEC [NVEC] = '{
    {3'd0, 8'd8, 8'd0, 32'd2},           // R3
    {3'd1, 8'd8, 8'd0, 32'hFFFF_FFFE},   // R3
    {3'd2, 8'd8, 8'd0, 32'd2},           // R4
    {3'd3, 8'd8, 8'd0, 32'd4},           // R4
    {3'd4, 8'd8, 8'd0, 32'd8},           // R5
    {3'd5, 8'd8, 8'd3, 32'd0},           // R6
    {3'd0, 8'd8, 8'd3, 32'd3},           // R3
    {3'd1, 8'd8, 8'd3, 32'hFFFF_FFFF},   // R3
    {3'd2, 8'd8, 8'd3, 32'd1},           // R4
    {3'd3, 8'd8, 8'd3, 32'd3},           // R4
    {3'd4, 8'd8, 8'd3, 32'd5}            // R5
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        phase_a_i = 1'b0, phase_b_i = 1'b0, irq_o;
  int          n_chk = 0, n_fail = 0, idx = 0;
  bit          ended = 1'b0;

  quad_pulse_counter u_quad_pulse_counter (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] cw(input bit en, input bit cont, input int mode, input bit snap);
    return 32'h00BB_0000 | (32'(snap) << 7) | (32'(mode[2:0]) << 3) | (32'(cont) << 1) | 32'(en);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drive_phase();
    phase_a_i = (idx == 1) || (idx == 2);
    phase_b_i = (idx >= 2);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic step(input int dir);
    idx = (idx + dir) & 3;
    drive_phase();
  endtask

  task automatic park();
    wr(A_CTRL, cw(0, 0, 0, 0));
    idx = 0;
    drive_phase();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 window", A_WIN, 0);
    rd_chk("R1 result", A_RES, 0);
    rd_chk("R1 live", A_LIVE, 0);
    rd_chk("R1 status", A_STAT, 0);
    check("R1 irq", 32'(irq_o), 0);

    // R2 masked writes
    wr(A_CTRL, 32'h0000_00BB);
    rd_chk("R2 unmasked ctrl ignored", A_CTRL, 0);
    wr(A_CTRL, 32'h0002_00BB);
    rd_chk("R2 partial mask", A_CTRL, 32'h0000_0002);
    wr(A_CTRL, 32'h00BB_00B8);
    rd_chk("R2 full mask", A_CTRL, 32'h0000_00B8);
    wr(A_CTRL, cw(0, 0, 0, 0));
    wr(A_WIN, 32'd400);
    rd_chk("R2 window", A_WIN, 32'd400);

    // table of modes and step patterns
    for (int v = 0; v < NVEC; v++) begin
      int mode, nf, nr;
      mode = int'(VEC[v][50:48]);
      nf   = int'(VEC[v][47:40]);
      nr   = int'(VEC[v][39:32]);
      park();
      wr(A_CTRL, cw(1, 0, mode, 0));
      for (int s = 0; s < nf; s++) step(1);
      for (int s = 0; s < nr; s++) step(-1);
      repeat (400) @(negedge clk_i);
      rd_chk($sformatf("R3/R4/R5/R6 vec%0d mode%0d", v, mode), A_RES, VEC[v][31:0]);
    end

    // R5 double transition ignored
    park();
    wr(A_CTRL, cw(1, 0, 4, 0));
    step(1);                                  // 00->10 up
    phase_a_i = 1'b0; phase_b_i = 1'b1; idx = 3;
    repeat (4) @(negedge clk_i);              // 10->01 ignored
    step(1);                                  // 01->00 up
    repeat (400) @(negedge clk_i);
    rd_chk("R5 double change ignored", A_RES, 32'd2);

    // R7 / R10 window timing, status and irq
    park();
    wr(A_STAT, 32'd1);
    rd_chk("R10 status cleared", A_STAT, 0);
    wr(A_WIN, 32'd20);
    wr(A_CTRL, cw(1, 0, 0, 0));
    repeat (10) @(negedge clk_i);
    rd_chk("R7 status before window end", A_STAT, 0);
    repeat (15) @(negedge clk_i);
    rd_chk("R7 status after window end", A_STAT, 1);
    rd_chk("R7 result latched", A_RES, 0);
    check("R10 irq off while disabled", 32'(irq_o), 0);
    wr(A_IEN, 32'h0000_0001);
    check("R2 ien unmasked ignored", 32'(irq_o), 0);
    wr(A_IEN, 32'h0001_0001);
    check("R10 irq on", 32'(irq_o), 1);
    wr(A_STAT, 32'd0);
    rd_chk("R10 write 0 keeps status", A_STAT, 1);
    wr(A_STAT, 32'd1);
    rd_chk("R10 w1c", A_STAT, 0);
    check("R10 irq off", 32'(irq_o), 0);

    // R11 disable keeps result; run a 5-count first
    park();
    wr(A_WIN, 32'd400);
    wr(A_CTRL, cw(1, 0, 4, 0));
    for (int s = 0; s < 5; s++) step(1);
    repeat (400) @(negedge clk_i);
    wr(A_STAT, 32'd1);
    wr(A_CTRL, cw(0, 0, 4, 0));
    rd_chk("R11 result kept after disable", A_RES, 32'd5);

    // R8 zero window in one-shot
    park();
    wr(A_WIN, 32'd0);
    wr(A_CTRL, cw(1, 0, 4, 0));
    for (int s = 0; s < 4; s++) step(1);
    repeat (50) @(negedge clk_i);
    rd_chk("R8 no status", A_STAT, 0);
    rd_chk("R8 result unchanged", A_RES, 32'd5);
    rd_chk("R9 live untouched in one-shot", A_LIVE, 0);

    // R9 continuous with snapshot
    park();
    wr(A_WIN, 32'd200);
    wr(A_CTRL, cw(1, 1, 4, 1));
    for (int s = 0; s < 4; s++) step(1);
    rd_chk("R9 live before window end", A_LIVE, 0);
    repeat (220) @(negedge clk_i);
    rd_chk("R9 live snapshot", A_LIVE, 32'd4);
    for (int s = 0; s < 2; s++) step(1);
    repeat (200) @(negedge clk_i);
    rd_chk("R9 count carries across windows", A_LIVE, 32'd6);
    rd_chk("R9 no status in continuous", A_STAT, 0);
    rd_chk("R9 result untouched", A_RES, 32'd5);

    // R9 continuous without snapshot
    park();
    wr(A_CTRL, cw(1, 1, 4, 0));
    for (int s = 0; s < 3; s++) step(1);
    rd_chk("R9 live follows count", A_LIVE, 32'd3);

    finish_run();
  end
endmodule